// File: doc/BRIEF.md
# Parallel LCD Bus Timing Controller

This block is the master side of an asynchronous, 8080-style parallel bus for an LCD controller. A host hands it one word at a time through a valid/ready handshake. Each request carries a direction flag, a command-or-data flag and, for writes, a 16-bit word. The block turns every request into a single bus cycle. It pulls chip select low and keeps the selected strobe high through an address-setup phase. It then drives that strobe low for a data phase. A write gets one extra hold cycle, and a read samples the bus at the end of the strobe. Every access finishes with a one-cycle done pulse, and a read returns the sampled word with that pulse.

Read cycles and write cycles each have their own setup and data-phase lengths. These are elaboration parameters counted in system clock cycles. The defaults suit a 72 MHz clock: a read strobe of 26 cycles (at least 355 ns) and a write strobe of 1 cycle, with no setup phase in either direction. The bus drives data out of the block on a separate output path with an output enable, and reads it back on an input path, so that the pad can be built as a tristate outside the block.

Top module: `lcd_bus_master`

## Requirements
- R1: While reset is held and on leaving it, chip select, read strobe and write strobe are high, the output enable is low, done is low and ready is high.
- R2: A write accepted on a clock edge holds chip select low with the write strobe high for WR_SETUP cycles, then drives the write strobe low for WR_DATA cycles.
- R3: A read accepted on a clock edge holds chip select low with the read strobe high for RD_SETUP cycles, then drives the read strobe low for RD_DATA cycles.
- R4: A read captures the input bus on the clock edge that ends its last strobe-low cycle, and presents that word on rd_data in the cycle when done is high.
- R5: After the write strobe rises, chip select stays low and the write word stays driven with the enable high for exactly one cycle. In the next cycle the enable is low.
- R6: The data output enable is high only while a write holds chip select low, and there lcd_dq_o equals the accepted word. During reads and while idle it is low.
- R7: lcd_rs is 0 for a command request (req_cmd=1) and 1 for a data request (req_cmd=0), and it does not change while chip select is low.
- R8: done is high for exactly one cycle, in the first cycle after chip select is released. Chip select is high in that cycle, and ready is low whenever chip select is low.
- R9: A data-phase parameter of 0 gives a strobe one cycle wide.
- R10: During an access only the strobe that matches its direction goes low, and the other strobe stays high.
- R11: With default parameters a read strobe lasts 26 cycles and a write strobe lasts 1 cycle, with no setup cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, a request will be taken |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cmd | input | 1 | 1 = command word, 0 = data word |
| req_wdata | input | DATA_W | Word to write |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | DATA_W | Word captured by the last read |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_dq_o | output | DATA_W | Bus data driven by the block |
| lcd_dq_oe | output | 1 | Output enable for lcd_dq_o |
| lcd_dq_i | input | DATA_W | Bus data returned by the panel |

## Verification
On a read, the capture of the input bus falls in the same clock edge as the release of the read strobe and the release of chip select. An off-by-one error would capture one cycle early, or after the strobe has risen. To provoke this, the bench drives a junk value on the input bus in every strobe-low cycle but the last. In that last cycle it drives the expected word, then switches back to junk straight after the edge. A read is judged correct only if the word returned with done is the one present in the final strobe cycle. The same bench also counts the cycles of each phase against the parameters of two differently configured instances.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_GAP    = 3'd4
   } lcd_phase_e;

   // a strobe is never narrower than one clock
   function automatic int strobe_len(input int n);
      return (n < 1) ? 1 : n;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/lcd_phase_cnt.sv
module lcd_phase_cnt #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (load)           remain <= load_val;
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign last = (remain == '0);
endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
   import lcd_bus_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter int RD_SETUP = 0,
   parameter int RD_DATA  = 26,
   parameter int WR_SETUP = 0,
   parameter int WR_DATA  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             cnt_last,
   output logic             cnt_load,
   output logic [CNT_W-1:0] cnt_val,
   output lcd_phase_e       phase,
   output logic             is_write,
   output logic             accept,
   output logic             sample,
   output logic             done_set
);
   localparam int RD_STB = strobe_len(RD_DATA);
   localparam int WR_STB = strobe_len(WR_DATA);
   localparam logic [CNT_W-1:0] RD_STB_M1 = CNT_W'(RD_STB - 1);
   localparam logic [CNT_W-1:0] WR_STB_M1 = CNT_W'(WR_STB - 1);

   lcd_phase_e phase_nx;
   logic       wr_nx;
   logic       rd_has_setup, wr_has_setup;
   logic [CNT_W-1:0] rd_setup_m1, wr_setup_m1;

   // the setup phase is built only in the directions that use it
   generate
      if (RD_SETUP > 0) begin : g_rd_setup
         assign rd_has_setup = 1'b1;
         assign rd_setup_m1  = CNT_W'(RD_SETUP - 1);
      end else begin : g_rd_nosetup
         assign rd_has_setup = 1'b0;
         assign rd_setup_m1  = '0;
      end
      if (WR_SETUP > 0) begin : g_wr_setup
         assign wr_has_setup = 1'b1;
         assign wr_setup_m1  = CNT_W'(WR_SETUP - 1);
      end else begin : g_wr_nosetup
         assign wr_has_setup = 1'b0;
         assign wr_setup_m1  = '0;
      end
   endgenerate

   assign accept = (phase == PH_IDLE) && req_valid;

   always_comb begin
      phase_nx = phase;
      wr_nx    = is_write;
      cnt_load = 1'b0;
      cnt_val  = '0;
      sample   = 1'b0;
      done_set = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            if (req_valid) begin
               wr_nx    = req_write;
               cnt_load = 1'b1;
               if (req_write ? wr_has_setup : rd_has_setup) begin
                  phase_nx = PH_SETUP;
                  cnt_val  = req_write ? wr_setup_m1 : rd_setup_m1;
               end else begin
                  phase_nx = PH_STROBE;
                  cnt_val  = req_write ? WR_STB_M1 : RD_STB_M1;
               end
            end
         end
         PH_SETUP: begin
            if (cnt_last) begin
               phase_nx = PH_STROBE;
               cnt_load = 1'b1;
               cnt_val  = is_write ? WR_STB_M1 : RD_STB_M1;
            end
         end
         PH_STROBE: begin
            if (cnt_last) begin
               if (is_write) begin
                  phase_nx = PH_HOLD;
               end else begin
                  phase_nx = PH_GAP;
                  sample   = 1'b1;
                  done_set = 1'b1;
               end
            end
         end
         PH_HOLD: begin
            phase_nx = PH_GAP;
            done_set = 1'b1;
         end
         PH_GAP:  phase_nx = PH_IDLE;
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         is_write <= 1'b0;
      end else begin
         phase    <= phase_nx;
         is_write <= wr_nx;
      end
   end
endmodule

// File: rtl/lcd_bus_dpath.sv
module lcd_bus_dpath #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              sample,
   input  logic              done_set,
   input  logic              req_cmd,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] lcd_dq_i,
   output logic              rs_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q,
   output logic              done_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_q    <= 1'b1;
         wdata_q <= '0;
         rdata_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (accept) begin
            rs_q    <= ~req_cmd;
            wdata_q <= req_wdata;
         end
         if (sample) rdata_q <= lcd_dq_i;
         done_q <= done_set;
      end
   end
endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
   import lcd_bus_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int RD_SETUP = 0,
   parameter int RD_DATA  = 26,
   parameter int WR_SETUP = 0,
   parameter int WR_DATA  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_cmd,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              lcd_cs_n,
   output logic              lcd_rd_n,
   output logic              lcd_wr_n,
   output logic              lcd_rs,
   output logic [DATA_W-1:0] lcd_dq_o,
   output logic              lcd_dq_oe,
   input  logic [DATA_W-1:0] lcd_dq_i
);
   localparam int MAX_CNT = max4(RD_SETUP, strobe_len(RD_DATA), WR_SETUP, strobe_len(WR_DATA));
   localparam int CNT_W   = $clog2(MAX_CNT + 2);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("lcd_bus_master: DATA_W must be at least 1");
      end
      if (RD_SETUP < 0 || WR_SETUP < 0 || RD_DATA < 0 || WR_DATA < 0) begin : g_bad_timing
         $error("lcd_bus_master: phase counts must not be negative");
      end
   endgenerate

   lcd_phase_e       phase;
   logic             is_write, accept, sample, done_set;
   logic             cnt_load, cnt_last;
   logic [CNT_W-1:0] cnt_val;
   logic             rs_q;
   logic [DATA_W-1:0] wdata_q;

   lcd_bus_seq #(
      .CNT_W(CNT_W), .RD_SETUP(RD_SETUP), .RD_DATA(RD_DATA),
      .WR_SETUP(WR_SETUP), .WR_DATA(WR_DATA)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .cnt_last(cnt_last), .cnt_load(cnt_load), .cnt_val(cnt_val),
      .phase(phase), .is_write(is_write), .accept(accept),
      .sample(sample), .done_set(done_set)
   );

   lcd_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .last(cnt_last)
   );

   lcd_bus_dpath #(.DATA_W(DATA_W)) u_dpath (
      .clk(clk), .rst_n(rst_n), .accept(accept), .sample(sample), .done_set(done_set),
      .req_cmd(req_cmd), .req_wdata(req_wdata), .lcd_dq_i(lcd_dq_i),
      .rs_q(rs_q), .wdata_q(wdata_q), .rdata_q(rd_data), .done_q(done)
   );

   logic active;
   assign active    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign req_ready = (phase == PH_IDLE);
   assign lcd_cs_n  = ~active;
   assign lcd_rd_n  = ~((phase == PH_STROBE) && !is_write);
   assign lcd_wr_n  = ~((phase == PH_STROBE) && is_write);
   assign lcd_dq_oe = active && is_write;
   assign lcd_rs    = rs_q;
   assign lcd_dq_o  = wdata_q;
endmodule

// File: rtl/lcd_bus_master_chk.sv
module lcd_bus_master_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              lcd_cs_n,
   input logic              lcd_rd_n,
   input logic              lcd_wr_n,
   input logic              lcd_rs,
   input logic [DATA_W-1:0] lcd_dq_o,
   input logic              lcd_dq_oe
);
   assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!lcd_rd_n && !lcd_wr_n));

   assert_strobe_in_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!lcd_rd_n || !lcd_wr_n) |-> !lcd_cs_n);

   assert_no_oe_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_rd_n |-> !lcd_dq_oe);

   assert_oe_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_dq_oe |-> !lcd_cs_n);

   assert_rs_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!lcd_cs_n) |=> (lcd_cs_n || $stable(lcd_rs)));

   assert_hold_driven_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_wr_n) |-> (lcd_dq_oe && !lcd_cs_n && $stable(lcd_dq_o)));

   assert_hold_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lcd_wr_n) |=> !lcd_dq_oe);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lcd_cs_n && $past(!lcd_cs_n)));

   assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lcd_cs_n |-> !req_ready);
endmodule

bind lcd_bus_master lcd_bus_master_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lcd_bus_master_tb.sv
module lcd_bus_master_tb;
   localparam int DW = 16;
   localparam int A_RS = 2, A_RD = 3, A_WS = 1, A_WD = 0;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          val_d = 1'b0, val_a = 1'b0;
   logic          r_wr = 1'b0, r_cmd = 1'b0;
   logic [DW-1:0] r_wdata = '0, dq_in = '0;

   logic          d_ready, d_done, d_cs, d_rd, d_wr, d_rs, d_oe;
   logic [DW-1:0] d_rdata, d_dq;
   logic          a_ready, a_done, a_cs, a_rd, a_wr, a_rs, a_oe;
   logic [DW-1:0] a_rdata, a_dq;

   lcd_bus_master u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(val_d), .req_ready(d_ready),
      .req_write(r_wr), .req_cmd(r_cmd), .req_wdata(r_wdata),
      .done(d_done), .rd_data(d_rdata), .lcd_cs_n(d_cs), .lcd_rd_n(d_rd),
      .lcd_wr_n(d_wr), .lcd_rs(d_rs), .lcd_dq_o(d_dq), .lcd_dq_oe(d_oe),
      .lcd_dq_i(dq_in)
   );

   lcd_bus_master #(.RD_SETUP(A_RS), .RD_DATA(A_RD), .WR_SETUP(A_WS), .WR_DATA(A_WD)) u_alt (
      .clk(clk), .rst_n(rst_n), .req_valid(val_a), .req_ready(a_ready),
      .req_write(r_wr), .req_cmd(r_cmd), .req_wdata(r_wdata),
      .done(a_done), .rd_data(a_rdata), .lcd_cs_n(a_cs), .lcd_rd_n(a_rd),
      .lcd_wr_n(a_wr), .lcd_rs(a_rs), .lcd_dq_o(a_dq), .lcd_dq_oe(a_oe),
      .lcd_dq_i(dq_in)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one access on the selected instance, with phase lengths measured at negedges
   task automatic run_access(input bit alt, input bit wr, input bit cmd,
                             input logic [DW-1:0] wd, input logic [DW-1:0] rd_word,
                             input int exp_setup, input int exp_stb, input string tag);
      int n_setup = 0, n_stb = 0, n_hold = 0;
      bit seen_stb = 0, got_done = 0, oe_bad = 0, rs_bad = 0, other_bad = 0;
      bit rdy_bad = 0, dq_bad = 0, idle_oe_bad = 0;
      logic [DW-1:0] junk;
      junk = ~rd_word;
      @(negedge clk);
      dq_in   = junk;
      r_wr    = wr;
      r_cmd   = cmd;
      r_wdata = wd;
      if (alt) val_a = 1'b1; else val_d = 1'b1;
      @(posedge clk);
      #1;
      val_a = 1'b0;
      val_d = 1'b0;
      for (int i = 0; i < 100 && !got_done; i++) begin
         logic s_cs, s_rd, s_wr, s_rs, s_oe, s_done, s_rdy;
         logic [DW-1:0] s_dq, s_rdata;
         @(negedge clk);
         s_cs = alt ? a_cs : d_cs;   s_rd = alt ? a_rd : d_rd;
         s_wr = alt ? a_wr : d_wr;   s_rs = alt ? a_rs : d_rs;
         s_oe = alt ? a_oe : d_oe;   s_done = alt ? a_done : d_done;
         s_rdy = alt ? a_ready : d_ready;
         s_dq = alt ? a_dq : d_dq;   s_rdata = alt ? a_rdata : d_rdata;
         if (!s_cs) begin
            if (s_rdy) rdy_bad = 1;
            if (s_rs !== ~cmd) rs_bad = 1;
            if (wr ? !s_rd : !s_wr) other_bad = 1;
            if (s_oe !== wr) oe_bad = 1;
            if (wr && s_dq !== wd) dq_bad = 1;
            if (wr ? !s_wr : !s_rd) begin
               seen_stb = 1;
               n_stb++;
               dq_in = (!wr && n_stb == exp_stb) ? rd_word : junk;
            end else if (!seen_stb) begin
               n_setup++;
            end else begin
               n_hold++;
               dq_in = junk;
            end
         end else begin
            dq_in = junk;
            if (s_oe) idle_oe_bad = 1;
            if (s_done) begin
               got_done = 1;
               if (!wr) chk(s_rdata === rd_word, {tag, " R4 read word"}, int'(s_rdata), int'(rd_word));
            end
         end
      end
      chk(got_done, {tag, " R8 done seen"}, int'(got_done), 1);
      chk(n_setup == exp_setup, {tag, wr ? " R2 write setup" : " R3 read setup"}, n_setup, exp_setup);
      chk(n_stb == exp_stb, {tag, wr ? " R2 write strobe" : " R3 read strobe"}, n_stb, exp_stb);
      chk(n_hold == (wr ? 1 : 0), {tag, " R5 hold cycles"}, n_hold, wr ? 1 : 0);
      chk(!oe_bad && !idle_oe_bad && !dq_bad, {tag, " R6 output enable/data"}, int'(oe_bad | idle_oe_bad | dq_bad), 0);
      chk(!rs_bad, {tag, " R7 register select"}, int'(rs_bad), 0);
      chk(!other_bad, {tag, " R10 other strobe"}, int'(other_bad), 0);
      chk(!rdy_bad, {tag, " R8 ready while busy"}, int'(rdy_bad), 0);
      @(negedge clk);
      chk((alt ? a_done : d_done) == 1'b0, {tag, " R8 done one cycle"}, int'(alt ? a_done : d_done), 0);
      chk((alt ? a_oe : d_oe) == 1'b0, {tag, " R5 oe off after hold"}, int'(alt ? a_oe : d_oe), 0);
   endtask

   task automatic test_reset();
      @(negedge clk);
      chk(d_cs && d_rd && d_wr, "R1 strobes high in reset", int'({d_cs, d_rd, d_wr}), 7);
      chk(!d_oe && !d_done && d_ready, "R1 oe/done/ready in reset", int'({d_oe, d_done, d_ready}), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(a_cs && a_rd && a_wr && !a_oe && a_ready && !a_done, "R1 idle after reset",
          int'({a_cs, a_rd, a_wr, a_oe, a_ready, a_done}), 6'b111010);
   endtask

   task automatic test_default_write();
      run_access(1'b0, 1'b1, 1'b1, 16'h002C, '0, 0, 1, "default cmd write R11");
      run_access(1'b0, 1'b1, 1'b0, 16'hF81F, '0, 0, 1, "default data write R11");
   endtask

   task automatic test_default_read();
      run_access(1'b0, 1'b0, 1'b0, '0, 16'h9341, 0, 26, "default read R11");
   endtask

   task automatic test_zero_data_write();
      run_access(1'b1, 1'b1, 1'b0, 16'h1234, '0, A_WS, 1, "alt write R9");
   endtask

   task automatic test_alt_read();
      run_access(1'b1, 1'b0, 1'b1, '0, 16'hA5C3, A_RS, A_RD, "alt cmd read");
      run_access(1'b1, 1'b0, 1'b0, '0, 16'h0001, A_RS, A_RD, "alt data read");
   endtask

   task automatic test_back_to_back();
      run_access(1'b1, 1'b1, 1'b1, 16'hFFFF, '0, A_WS, 1, "b2b first");
      run_access(1'b1, 1'b0, 1'b0, '0, 16'h8000, A_RS, A_RD, "b2b second");
      run_access(1'b1, 1'b1, 1'b0, 16'h0000, '0, A_WS, 1, "b2b third");
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL R8 watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      test_reset();
      test_default_write();
      test_default_read();
      test_zero_data_write();
      test_alt_read();
      test_back_to_back();
      repeat (2) @(posedge clk);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule